// File: doc/BRIEF.md
# Multi-DAC Serial Host Controller

This block sits on the host side of a bank of serial-input DACs that share one serial clock line and one serial data line. It takes commands over a valid/ready interface. Each command names a target device, an operation and a 16-bit word. The block then produces the serial clock, the data line, one active-low frame select per device, a load strobe, a read-frame strobe and a clear strobe. A write shifts the word out MSB first with a frame select held low. A read drops the shared read-frame strobe and captures the device's serial output into a 16-bit result.

The serial clock runs from a divider on the system clock. Every half period of the serial clock lasts `cmd_div + 1` system clocks, and the divider value is taken with each command. A write can be split into two bytes: the clock pauses between the bytes while the frame select stays low. A deferred write ends with a load pulse that the host issues after the frame is released. Between frames the block holds every strobe released for at least one serial clock period, and only then accepts the next command.

Top module: `dacbank_host`

## Requirements
- R1: After synchronous reset, and whenever no command is in progress, `sclk` and `sdin` are 0, all of `sync_n`, `ldac_n`, `rben_n` and `clr_n` are 1, `rd_done` is 0 and `cmd_ready` is 1.
- R2: A write drives only bit `cmd_dev` of `sync_n` low. At most one `sync_n` bit is ever low, and reads and clears never drive `sync_n` low.
- R3: Every serial half period lasts `cmd_div+1` clocks. A write frame is one low-clock half period with the select low, then 16 periods, each a high half then a low half. Data bit 15-k is presented on `sdin` for the k-th period, and `sdin` changes only where `sclk` rises.
- R4: When `cmd_split` is 1 on a write, the clock stays low for two extra half periods after the eighth falling edge, with the select still low and `sdin` unchanged.
- R5: After the last falling edge the select stays low for one more half period. Then every strobe is released for two half periods (one serial period) before `cmd_ready` returns. The select only rises while `sclk` is low.
- R6: `cmd_op` encoding: 2'b00 write, 2'b01 write with load, 2'b10 read, 2'b11 clear. For 2'b01, `ldac_n` goes low for two half periods right after the release gap, and only while every select is high.
- R7: A read drops `rben_n` with `sdin` held 0 and runs the same 16-period clock as a write. It samples `sdo` at each falling edge, first bit into bit 15, and raises `rben_n` after the trailing half period. In that same cycle `rd_done` pulses for exactly one clock with the captured word on `rd_data`.
- R8: A clear drives `clr_n` low for two half periods. `sclk` stays low and every select and `rben_n` stay high throughout.
- R9: `cmd_ready` is 1 exactly when idle, and `busy` is its inverse. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. Command inputs have no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command will be taken |
| cmd_dev | input | IDX_W (2) | Target device index |
| cmd_op | input | 2 | Operation code (see R6) |
| cmd_split | input | 1 | Send a write as two bytes with a mid-frame pause |
| cmd_data | input | WORD_W (16) | Word to write |
| cmd_div | input | DIV_W (8) | Half-period length minus one, in clocks |
| busy | output | 1 | Command in progress |
| sclk | output | 1 | Shared serial clock, idle low |
| sdin | output | 1 | Shared serial data to the devices |
| sync_n | output | NUM_DEV (4) | Per-device active-low frame select |
| ldac_n | output | 1 | Active-low load strobe |
| rben_n | output | 1 | Active-low read frame strobe |
| clr_n | output | 1 | Active-low clear strobe |
| sdo | input | 1 | Serial data returned from the devices |
| rd_data | output | WORD_W (16) | Captured read word |
| rd_done | output | 1 | One-clock pulse when `rd_data` is valid |

## Verification
The two events that share a cycle are the end of one frame's release gap and the hand-over to the next command. With `cmd_valid` already held high while busy, `cmd_ready` rises and the next frame's first edge lands on the clock right after it. The bench issues commands back to back with different dividers, devices and split settings to provoke this. A per-cycle reference model of the expected pin levels judges that the gap lasts exactly two half periods and that the next select falls with no cycle lost or added. A queued command's fields are also changed while the block is busy, and the pins are checked to be unaffected.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  typedef enum logic [1:0] {
    OP_WR  = 2'b00,
    OP_WRL = 2'b01,
    OP_RD  = 2'b10,
    OP_CLR = 2'b11
  } op_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HI,
    ST_LO,
    ST_PAUSE,
    ST_TAIL,
    ST_GAP,
    ST_LDAC,
    ST_CLRP
  } st_t;
endpackage

// File: rtl/dacbank_tick.sv
module dacbank_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dacbank_sel.sv
module dacbank_sel #(
  parameter int NUM_DEV = 4,
  parameter int IDX_W   = 2
) (
  input  logic               en,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_DEV-1:0] oh
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dec
    assign oh[g] = en && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/dacbank_cap.sv
module dacbank_cap #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end
endmodule

// File: rtl/dacbank_host.sv
module dacbank_host
  import dacbank_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int DIV_W    = 8,
  parameter int WORD_W   = 16,
  parameter int SPLIT_AT = 8,
  localparam int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int CNT_W   = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [IDX_W-1:0]   cmd_dev,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_split,
  input  logic [WORD_W-1:0]  cmd_data,
  input  logic [DIV_W-1:0]   cmd_div,
  output logic               busy,
  output logic               sclk,
  output logic               sdin,
  output logic [NUM_DEV-1:0] sync_n,
  output logic               ldac_n,
  output logic               rben_n,
  output logic               clr_n,
  input  logic               sdo,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_done
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] SPLIT_IDX = CNT_W'(SPLIT_AT - 1);

  st_t               st;
  op_t               op_q;
  logic              split_q;
  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  bitc;
  logic              hold;
  logic [DIV_W-1:0]  div_q;
  logic              tick;
  logic              start;
  logic              is_wr;
  logic              cap_en;
  logic [NUM_DEV-1:0] sel_oh;

  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign start     = cmd_valid && cmd_ready;
  assign is_wr     = (op_q == OP_WR) || (op_q == OP_WRL);
  assign cap_en    = tick && (st == ST_HI) && (op_q == OP_RD);

  dacbank_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .restart(start), .div(div_q), .tick(tick)
  );

  dacbank_sel #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_sel (
    .en(start && !cmd_op[1]), .idx(cmd_dev), .oh(sel_oh)
  );

  dacbank_cap #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .shift_en(cap_en), .din(sdo), .word(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      op_q    <= OP_WR;
      split_q <= 1'b0;
      sreg    <= '0;
      bitc    <= '0;
      hold    <= 1'b0;
      div_q   <= '0;
      sclk    <= 1'b0;
      sdin    <= 1'b0;
      sync_n  <= '1;
      ldac_n  <= 1'b1;
      rben_n  <= 1'b1;
      clr_n   <= 1'b1;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= op_t'(cmd_op);
          split_q <= cmd_split;
          sreg    <= cmd_data;
          bitc    <= '0;
          hold    <= 1'b0;
          div_q   <= cmd_div;
          case (cmd_op)
            OP_RD:   begin rben_n <= 1'b0; st <= ST_LEAD; end
            OP_CLR:  begin clr_n  <= 1'b0; st <= ST_CLRP; end
            default: begin sync_n <= ~sel_oh; st <= ST_LEAD; end
          endcase
        end
        ST_LEAD: if (tick) begin
          sclk <= 1'b1;
          sdin <= is_wr && sreg[WORD_W-1];
          st   <= ST_HI;
        end
        ST_HI: if (tick) begin
          sclk <= 1'b0;
          st   <= ST_LO;
        end
        ST_LO: if (tick) begin
          if (bitc == LAST_BIT) begin
            st <= ST_TAIL;
          end else if (split_q && is_wr && bitc == SPLIT_IDX) begin
            hold <= 1'b0;
            st   <= ST_PAUSE;
          end else begin
            sclk <= 1'b1;
            sdin <= is_wr && sreg[WORD_W-2];
            sreg <= sreg << 1;
            bitc <= bitc + 1'b1;
            st   <= ST_HI;
          end
        end
        ST_PAUSE: if (tick) begin
          if (!hold) begin
            hold <= 1'b1;
          end else begin
            hold <= 1'b0;
            sclk <= 1'b1;
            sdin <= sreg[WORD_W-2];
            sreg <= sreg << 1;
            bitc <= bitc + 1'b1;
            st   <= ST_HI;
          end
        end
        ST_TAIL: if (tick) begin
          sync_n  <= '1;
          rben_n  <= 1'b1;
          sdin    <= 1'b0;
          rd_done <= (op_q == OP_RD);
          hold    <= 1'b0;
          st      <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (!hold) begin
            hold <= 1'b1;
          end else begin
            hold <= 1'b0;
            if (op_q == OP_WRL) begin
              ldac_n <= 1'b0;
              st     <= ST_LDAC;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_LDAC: if (tick) begin
          if (!hold) hold <= 1'b1;
          else begin
            hold   <= 1'b0;
            ldac_n <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_CLRP: if (tick) begin
          if (!hold) hold <= 1'b1;
          else begin
            hold  <= 1'b0;
            clr_n <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sync_n)); // R2
  AST_READ_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    !rben_n |-> (&sync_n)); // R2
  AST_SDIN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (!(&sync_n) && !$rose(sclk)) |-> $stable(sdin)); // R3
  AST_RELEASE_LOW_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(&sync_n) |-> (!sclk && !$past(sclk))); // R5
  AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    !ldac_n |-> ((&sync_n) && rben_n && !sclk)); // R6
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> ($rose(rben_n) && !$past(rd_done))); // R7
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> ((&sync_n) && rben_n && !sclk && ldac_n)); // R8
endmodule

// File: tb/tb_dacbank_host.sv
`timescale 1ns/1ps
module tb_dacbank_host;
  localparam int N  = 4;
  localparam int W  = N + 6;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_dev = '0;
  logic [1:0] cmd_op = '0;
  logic cmd_split = 1'b0;
  logic [WD-1:0] cmd_data = '0;
  logic [7:0] cmd_div = '0;
  logic busy, sclk, sdin, ldac_n, rben_n, clr_n, rd_done;
  logic [N-1:0] sync_n;
  logic sdo = 1'b0;
  logic [WD-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] q[$];
  string tq[$];
  logic [WD-1:0] dev_word = '0;
  logic [WD-1:0] exp_rd = '0;
  int ridx = 0;

  always #2.5 clk = ~clk;

  dacbank_host dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_op(cmd_op), .cmd_split(cmd_split),
    .cmd_data(cmd_data), .cmd_div(cmd_div), .busy(busy), .sclk(sclk),
    .sdin(sdin), .sync_n(sync_n), .ldac_n(ldac_n), .rben_n(rben_n),
    .clr_n(clr_n), .sdo(sdo), .rd_data(rd_data), .rd_done(rd_done)
  );

  // Device model: shifts its word out MSB first on each rising clock in a read frame
  always @(posedge sclk or posedge rben_n) begin
    if (rben_n) ridx = 0;
    else begin
      sdo = dev_word[15 - ridx];
      ridx = ridx + 1;
    end
  end

  function automatic logic [W-1:0] mk(input logic c, input logic d, input logic [N-1:0] s,
                                      input logic ld, input logic rb, input logic cl, input logic dn);
    return {dn, cl, rb, ld, s, d, c};
  endfunction

  task automatic push(input logic [W-1:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q.push_back(v);
      tq.push_back(tag);
    end
  endtask

  task automatic build(input int dev, input int op, input logic [WD-1:0] d,
                       input logic sp, input int dv);
    int L;
    logic [N-1:0] s;
    logic [N-1:0] rel;
    L = dv + 1;
    rel = '1;
    if (op == 3) begin
      push(mk(0, 0, rel, 1, 1, 0, 0), 2 * L, "R8");
    end else if (op == 2) begin
      exp_rd = dev_word;
      push(mk(0, 0, rel, 1, 0, 1, 0), L, "R7");
      for (int b = 0; b < 16; b++) begin
        push(mk(1, 0, rel, 1, 0, 1, 0), L, "R7");
        push(mk(0, 0, rel, 1, 0, 1, 0), L, "R7");
      end
      push(mk(0, 0, rel, 1, 0, 1, 0), L, "R7");
      push(mk(0, 0, rel, 1, 1, 1, 1), 1, "R7");
      push(mk(0, 0, rel, 1, 1, 1, 0), 2 * L - 1, "R5");
    end else begin
      s = ~(N'(1) << dev);
      push(mk(0, 0, s, 1, 1, 1, 0), L, "R2");
      for (int b = 0; b < 16; b++) begin
        push(mk(1, d[15 - b], s, 1, 1, 1, 0), L, "R3");
        push(mk(0, d[15 - b], s, 1, 1, 1, 0), L, "R3");
        if (sp && b == 7) push(mk(0, d[15 - b], s, 1, 1, 1, 0), 2 * L, "R4");
      end
      push(mk(0, d[0], s, 1, 1, 1, 0), L, "R5");
      push(mk(0, 0, rel, 1, 1, 1, 0), 2 * L, "R5");
      if (op == 1) push(mk(0, 0, rel, 0, 1, 1, 0), 2 * L, "R6");
    end
  endtask

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    logic [W-1:0] ex;
    logic [W-1:0] act;
    string tag;
    if (!rst) begin
      act = mk(sclk, sdin, sync_n, ldac_n, rben_n, clr_n, rd_done);
      ex = (q.size() != 0) ? q[0] : mk(0, 0, '1, 1, 1, 1, 0);
      tag = (q.size() != 0) ? tq[0] : "R1";
      checks++;
      if (act !== ex) begin
        fails++;
        $display("FAIL %s pins act=%b exp=%b at %0t", tag, act, ex, $time);
      end
      checks++;
      if (cmd_ready !== (q.size() == 0) || busy !== (q.size() != 0)) begin
        fails++;
        $display("FAIL R9 ready/busy act=%b/%b exp=%b/%b", cmd_ready, busy,
                 q.size() == 0, q.size() != 0);
      end
      if (rd_done) begin
        checks++;
        if (rd_data !== exp_rd) begin
          fails++;
          $display("FAIL R7 rd_data act=%h exp=%h", rd_data, exp_rd);
        end
      end
      if (q.size() != 0) begin
        void'(q.pop_front());
        void'(tq.pop_front());
      end
      if (cmd_valid && cmd_ready) build(cmd_dev, cmd_op, cmd_data, cmd_split, cmd_div);
    end
  end

  task automatic send(input int dev, input int op, input logic [WD-1:0] d,
                      input logic sp, input int dv);
    cmd_valid = 1'b1;
    cmd_dev = 2'(dev);
    cmd_op = 2'(op);
    cmd_data = d;
    cmd_split = sp;
    cmd_div = 8'(dv);
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    // R9: scramble the fields while busy; pins must not react
    cmd_dev = ~cmd_dev;
    cmd_op = ~cmd_op;
    cmd_data = ~cmd_data;
    cmd_split = ~cmd_split;
    cmd_div = 8'd7;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    send(2, 0, 16'hA5C3, 1'b0, 1);          // R3 plain write
    send(0, 1, 16'h1234, 1'b1, 0);          // R4 split, R6 load
    dev_word = 16'hBEEF;
    send(1, 2, 16'h0F0F, 1'b0, 2);          // R7 read
    send(3, 3, 16'hFFFF, 1'b0, 1);          // R8 clear
    send(3, 0, 16'h8001, 1'b1, 1);          // R9 back to back
    send(1, 1, 16'h7FFE, 1'b0, 0);
    dev_word = 16'h0001;
    send(0, 2, 16'h0000, 1'b1, 0);          // R7 read, split ignored
    send(3, 1, 16'hFFFF, 1'b0, 3);          // R2 top index
    while (q.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung act=busy exp=done");
    summary();
    $finish;
  end
endmodule